// File: doc/BRIEF.md
# Seven-to-one lane serializer

This block turns a 28-bit pixel word into four serial data lanes and one forwarded-clock lane. Twenty-four bits carry colour. The other four carry panel timing: line sync, frame sync, data-ready and a spare control bit. The caller assigns these bits to word positions. The block places no meaning on them.

The block runs on a bit clock at seven times the pixel rate. A pixel-rate enable, `pix_en`, marks the bit-clock edge that stands for the falling edge of the pixel clock. At that edge the whole word is captured. Each lane then shifts out its seven-bit slice, one bit per bit clock. The clock lane repeats a fixed seven-slot pattern, so a receiver can find each word boundary. The supported pixel range is 20 to 65 MHz, which gives up to 455 Mbps per lane.

While power-down is asserted, all five lanes sit at 0. On release, the block refills its shift stages for seven bit clocks before it accepts a word. The same holds after reset.

Top module: `lane_ser7`

## Requirements
- R1: A word is captured only at a bit-clock edge where `pix_en` is high and the block is armed. All 28 bits are sent within the seven bit clocks that follow.
- R2: Lane n carries word bits 7n to 7n+6, and bit 7n is sent first. Slot k of a word captured at edge E is the output value during the bit cycle after edge E+k, for k = 0 to 6.
- R3: The clock lane gives 1,1,0,0,0,1,1 in slots 0 to 6 of every captured word.
- R4: `px_word` has no effect at edges where `pix_en` is low.
- R5: If `pix_en` arrives before all seven slots have gone out, the lanes restart at slot 0 with the new word.
- R6: At any edge where `pwr_dn` is high, all five outputs go to 0 for the following bit cycle, and the block disarms.
- R7: After reset or power-down is released, `pix_en` is ignored until seven edges have passed with `pwr_dn` low. The eighth such edge is the first that can capture.
- R8: After slot 6, if no new word has been captured, all five outputs are 0.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-rate enable; marks the capture edge |
| pwr_dn | input | 1 | Power-down; silences the outputs and disarms the block |
| px_word | input | 28 | Parallel word: colour bits and four control bits |
| lane_out | output | 4 | Serial data lanes, bit 0 is lane 0 |
| clk_lane | output | 1 | Forwarded clock lane |

## Verification
The bench builds the block with its default parameters: four lanes and a ratio of seven, with the 1100011 clock pattern. This puts every slot position of every lane within reach. It also covers the full seven-cycle arming window and the 28-bit word boundary.

Random enable timing produces early restarts and long idle gaps. Random power-down pulses land at every slot. Directed cases place the first enable at release offsets 6, 7 and 8, so both sides of the arming edge are checked.

// File: rtl/lane_ser7.sv
module lane_ser7 #(
  parameter int LANES = 4,
  parameter int RATIO = 7,
  parameter logic [RATIO-1:0] CLK_PAT = 7'b1100011
) (
  input  logic                   bit_clk,
  input  logic                   rst_n,
  input  logic                   pix_en,
  input  logic                   pwr_dn,
  input  logic [LANES*RATIO-1:0] px_word,
  output logic [LANES-1:0]       lane_out,
  output logic                   clk_lane
);
  localparam int WW = $clog2(RATIO + 1);
  localparam logic [WW-1:0] FULL = WW'(RATIO);

  logic [WW-1:0]    warm;
  logic [RATIO-1:0] csh;
  logic             armed, load;

  assign armed = (warm == FULL);
  assign load  = pix_en & armed & ~pwr_dn;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      warm <= '0;
      csh  <= '0;
    end else if (pwr_dn) begin
      warm <= '0;
      csh  <= '0;
    end else begin
      if (!armed) warm <= warm + 1'b1;
      csh <= load ? CLK_PAT : (csh >> 1);
    end
  end

  assign clk_lane = csh[0];

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [RATIO-1:0] sh;
    always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n)      sh <= '0;
      else if (pwr_dn) sh <= '0;
      else if (load)   sh <= px_word[n*RATIO +: RATIO];
      else             sh <= sh >> 1;
    end
    assign lane_out[n] = sh[0];
  end

  logic [LANES-1:0] slot0_bits;
  always_comb
    for (int n = 0; n < LANES; n++) slot0_bits[n] = px_word[n*RATIO];

  // R2: the first slot of each lane is the lowest bit of its slice
  a_r2_slot0_order: assert property (@(posedge bit_clk) disable iff (!rst_n)
    load |=> lane_out == $past(slot0_bits));

  // R3: the clock lane opens each word high
  a_r3_clk_head: assert property (@(posedge bit_clk) disable iff (!rst_n)
    load |=> clk_lane);

  // R3: slot 2 of the clock lane is low
  a_r3_clk_gap: assert property (@(posedge bit_clk) disable iff (!rst_n)
    load ##1 (!pix_en && !pwr_dn) ##1 (!pix_en && !pwr_dn) |=> !clk_lane);

  // R6: power-down silences every lane
  a_r6_pd_quiet: assert property (@(posedge bit_clk) disable iff (!rst_n)
    pwr_dn |=> (lane_out == '0) && !clk_lane);

  // R7: nothing is sent while the block is still arming
  a_r7_cold_silent: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !armed |=> (lane_out == '0) && !clk_lane);
endmodule

// File: tb/lane_ser7_test.sv
module lane_ser7_test;
  logic        bit_clk = 0;
  logic        rst_n = 0, pix_en = 0, pwr_dn = 0;
  logic [27:0] px_word = '0;
  logic [3:0]  lane_out;
  logic        clk_lane;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  lane_ser7 uut (.bit_clk, .rst_n, .pix_en, .pwr_dn, .px_word, .lane_out, .clk_lane);

  always #4 bit_clk = ~bit_clk;

  logic [27:0] m_word;
  int          m_slot = -1, m_quiet = 0;
  string       ctx = "R9";

  function automatic bit pat(int k);
    return (k == 0 || k == 1 || k == 5 || k == 6);
  endfunction

  function automatic logic [3:0] exp_lanes(logic [27:0] w, int k);
    logic [3:0] r;
    for (int n = 0; n < 4; n++) r[n] = w[7*n + k];
    return r;
  endfunction

  always @(posedge bit_clk) begin
    if (!rst_n) begin
      m_slot = -1; m_quiet = 0; ctx = "R9";
    end else if (pwr_dn) begin
      m_slot = -1; m_quiet = 0; ctx = "R6";
    end else begin
      if (pix_en && m_quiet >= 7) begin
        ctx = (m_slot >= 0 && m_slot < 6) ? "R5" : "R1 R2 R4";
        m_word = px_word; m_slot = 0;
      end else if (m_slot >= 0) begin
        m_slot++;
        if (m_slot >= 7) begin m_slot = -1; ctx = "R8"; end
        else if (ctx != "R5") ctx = "R1 R2 R4";
      end else ctx = (m_quiet < 7) ? "R7" : "R8";
      if (m_quiet < 7) m_quiet++;
    end
  end

  task automatic check_outs();
    logic [3:0] el;
    logic       ec;
    el = (m_slot >= 0) ? exp_lanes(m_word, m_slot) : 4'h0;
    ec = (m_slot >= 0) ? pat(m_slot) : 1'b0;
    n_chk++;
    if (lane_out !== el) begin
      n_bad++;
      $display("FAIL %s lanes slot %0d: got %h exp %h", ctx, m_slot, lane_out, el);
    end
    n_chk++;
    if (clk_lane !== ec) begin
      n_bad++;
      $display("FAIL R3 %s clock lane slot %0d: got %b exp %b", ctx, m_slot, clk_lane, ec);
    end
  endtask

  task automatic cyc(bit en, bit pd);
    @(negedge bit_clk);
    check_outs();
    pix_en = en; pwr_dn = pd; px_word = 28'($urandom);
  endtask

  initial begin
    void'($urandom(32'd7331));
    for (int i = 0; i < 5; i++) cyc(1, 0);
    @(negedge bit_clk); rst_n = 1;
    for (int i = 0; i < 7 * 200; i++) cyc(i % 7 == 0, 0);
    for (int i = 0; i < 6; i++) cyc(i == 2, 0);
    for (int d = 6; d <= 8; d++) begin
      for (int i = 0; i < 3; i++) cyc(0, 1);
      for (int i = 0; i < 20; i++) cyc(i == d || i == d + 7, 0);
    end
    for (int i = 0; i < 3000; i++) cyc(($urandom % 7) == 0, ($urandom % 40) == 0);
    for (int i = 0; i < 10; i++) cyc(0, 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule